// File: doc/BRIEF.md
# SD Command Path Engine

This block drives the command half of an SD host link. Host logic loads a 32-bit argument and then writes a 16-bit command word. That write starts the transaction. The block sends a 48-bit frame, most significant bit first, one bit per clock. The frame carries a CRC7 that the block computes itself. The block then listens on the returning command line for a reply of the type the command word asked for, and stores the reply's content in a 128-bit response output.

While a command is in flight, a present-state word shows that the command path is blocked. For replies that signal busy, it also shows that the data path is blocked, and it mirrors the live DAT0 level. Sticky status bits report completion, a missing reply, a CRC mismatch and an index mismatch. Software clears each status bit by writing a one to it. Data transfers are not handled: the only data-line input is DAT0, used for busy sensing.

Each clock cycle is one card-clock cycle. Clock division is left to the surrounding logic.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset, `int_status` is 0, `response` is 0, `cmd_oe` is 0 and `cmd_out` is 1. `present_state` is 0 except bit 20, which equals `dat0_in`.
- R2: An accepted command word is sent as a 48-bit frame, most significant bit first, starting in the cycle after the write, with `cmd_oe` high for exactly those 48 cycles. The frame is made of: start bit 0, direction bit 1, index = command word bits [13:8], the argument, CRC7 (polynomial x^7+x^3+1, seed 0, computed over the first 40 bits), and end bit 1.
- R3: `present_state` bit 0 is 1 from the cycle after an accepted write until the transaction ends. A command-word write while bit 0 is 1 is ignored: no frame is sent for it and the frame in progress is unchanged.
- R4: Command word bits [1:0] select the reply type. 00 = none, 01 = 136-bit, 10 = 48-bit, 11 = 48-bit followed by a busy wait. With type 00, the transaction ends on the clock edge that sends the end bit, and `int_status` bit 0 (done) is set at that edge.
- R5: A 48-bit reply (start 0, direction 0, 6-bit index, 32-bit payload, CRC7, end 1) puts its payload in `response[31:0]` and zero in `response[127:32]`. Done is set in the cycle that samples the reply's last bit.
- R6: A 136-bit reply (start 0, direction 0, 6 reserved bits, 120 content bits, CRC7, end 1) puts the 120 content bits in `response[119:0]` and zero in `response[127:120]`. The CRC and index checks do not apply to it.
- R7: After the end bit, the line is sampled for a start bit (0) on each of the next 64 clock edges. If none is seen, `int_status` bit 1 (timeout) is set, done is not set, and the transaction ends. A start bit on the 64th sample is accepted.
- R8: When command word bit 3 is 1, a 48-bit reply whose CRC7 differs from the one computed over its first 40 bits sets `int_status` bit 2. When bit 3 is 0, the mismatch has no effect.
- R9: When command word bit 4 is 1, a 48-bit reply whose index field differs from the sent index sets `int_status` bit 3. When bit 4 is 0, the mismatch has no effect.
- R10: For reply type 11, the transaction (and `present_state` bit 0) stays open after the reply until `dat0_in` is sampled high; done is set on that edge. `present_state` bit 1 is held for the same span only when command word bit 5 is 0. `present_state` bit 20 always shows `dat0_in`.
- R11: Writing `sts_wr` with a mask clears the `int_status` bits whose mask bit is 1. When a bit is set by an event in the same cycle it is cleared, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card-clock cycle each |
| rst_n | input | 1 | Asynchronous reset, active low |
| arg_wr | input | 1 | Load the argument register |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Write the command word, which starts a transaction |
| cmd_wdata | input | 16 | Command word: index [13:8], data-present [5], index check [4], CRC check [3], reply type [1:0] |
| sts_wr | input | 1 | Write-one-to-clear strobe for the status bits |
| sts_wdata | input | 4 | Mask of the status bits to clear |
| cmd_in | input | 1 | Sampled command line (reply from the card) |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| dat0_in | input | 1 | Sampled DAT0 line, used for busy |
| present_state | output | 32 | Bit 0 command inhibit, bit 1 data inhibit, bit 20 DAT0 level |
| int_status | output | 4 | Bit 0 done, bit 1 timeout, bit 2 CRC error, bit 3 index error |
| response | output | 128 | Stored reply content |

## Verification
Completion of a reply and a software clear of the status bits can land on the same clock edge. The bench provokes this by raising the write-one-to-clear strobe in the same cycle as the last reply bit. Its mask covers both the done bit and an older timeout bit. The outcome is judged by expecting done to stay set while the timeout bit goes to zero. A second overlap is also checked: a command-word write during an outgoing frame must leave that frame intact, which the scoreboard monitor confirms, and must produce no extra frame.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int RSP_TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arg_wr,
  input  logic [31:0]  arg_wdata,
  input  logic         cmd_wr,
  input  logic [15:0]  cmd_wdata,
  input  logic         sts_wr,
  input  logic [3:0]   sts_wdata,
  input  logic         cmd_in,
  output logic         cmd_out,
  output logic         cmd_oe,
  input  logic         dat0_in,
  output logic [31:0]  present_state,
  output logic [3:0]   int_status,
  output logic [127:0] response
);
  localparam int TW = $clog2(RSP_TIMEOUT) + 1;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RECV, S_BUSY} st_t;

  st_t            st;
  logic [31:0]    arg_q;
  logic [5:0]     idx_q;
  logic [1:0]     rtype_q;
  logic           chk_crc_q, chk_idx_q;
  logic [47:0]    tx_sr;
  logic [7:0]     cnt;
  logic [TW-1:0]  wcnt;
  logic [134:0]   rx_sr;
  logic           inh_cmd, inh_dat;
  logic [3:0]     sts_q;
  logic [127:0]   rsp_q;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  wire [31:0]  arg_src = arg_wr ? arg_wdata : arg_q;
  wire [39:0]  tx_head = {2'b01, cmd_wdata[13:8], arg_src};
  wire         accept  = cmd_wr && !inh_cmd;

  wire [134:0] rx_nxt  = {rx_sr[133:0], cmd_in};
  wire [6:0]   rx_crc  = crc7({1'b0, rx_nxt[46:8]});
  wire         crc_bad = chk_crc_q && rtype_q[1] && (rx_crc != rx_nxt[7:1]);
  wire         idx_bad = chk_idx_q && rtype_q[1] && (rx_nxt[45:40] != idx_q);

  wire fin_send = (st == S_SEND) && (cnt == 8'd0);
  wire fin_rx   = (st == S_RECV) && (cnt == 8'd0);
  wire t_out    = (st == S_WAIT) && cmd_in && (wcnt == TW'(RSP_TIMEOUT - 1));
  wire done_ev  = (fin_send && rtype_q == 2'b00) ||
                  (fin_rx && rtype_q != 2'b11) ||
                  ((st == S_BUSY) && dat0_in);
  wire [3:0] set_vec = {idx_bad && fin_rx, crc_bad && fin_rx, t_out, done_ev};

  wire unused_ok = ^{cmd_wdata[15:14], cmd_wdata[7:6], cmd_wdata[2], rx_nxt[134:128], rx_nxt[0]};

  assign cmd_oe        = (st == S_SEND);
  assign cmd_out       = cmd_oe ? tx_sr[47] : 1'b1;
  assign present_state = {11'd0, dat0_in, 18'd0, inh_dat, inh_cmd};
  assign int_status    = sts_q;
  assign response      = rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      arg_q     <= '0;
      idx_q     <= '0;
      rtype_q   <= '0;
      chk_crc_q <= 1'b0;
      chk_idx_q <= 1'b0;
      tx_sr     <= '0;
      cnt       <= '0;
      wcnt      <= '0;
      rx_sr     <= '0;
    end else begin
      if (arg_wr) arg_q <= arg_wdata;
      case (st)
        S_IDLE: if (accept) begin
          st        <= S_SEND;
          idx_q     <= cmd_wdata[13:8];
          rtype_q   <= cmd_wdata[1:0];
          chk_crc_q <= cmd_wdata[3];
          chk_idx_q <= cmd_wdata[4];
          tx_sr     <= {tx_head, crc7(tx_head), 1'b1};
          cnt       <= 8'd47;
        end
        S_SEND: begin
          tx_sr <= {tx_sr[46:0], 1'b1};
          if (cnt == 8'd0) begin
            st   <= (rtype_q == 2'b00) ? S_IDLE : S_WAIT;
            wcnt <= '0;
          end else cnt <= cnt - 8'd1;
        end
        S_WAIT: begin
          if (!cmd_in) begin
            st    <= S_RECV;
            cnt   <= (rtype_q == 2'b01) ? 8'd134 : 8'd46;
            rx_sr <= '0;
          end else if (t_out) st <= S_IDLE;
          else wcnt <= wcnt + 1'b1;
        end
        S_RECV: begin
          rx_sr <= rx_nxt;
          if (cnt == 8'd0) st <= (rtype_q == 2'b11) ? S_BUSY : S_IDLE;
          else cnt <= cnt - 8'd1;
        end
        S_BUSY: if (dat0_in) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_cmd <= 1'b0;
      inh_dat <= 1'b0;
      sts_q   <= '0;
      rsp_q   <= '0;
    end else begin
      if (accept) begin
        inh_cmd <= 1'b1;
        inh_dat <= (cmd_wdata[1:0] == 2'b11) && !cmd_wdata[5];
      end else if (done_ev || t_out) begin
        inh_cmd <= 1'b0;
        inh_dat <= 1'b0;
      end
      sts_q <= (sts_q & ~(sts_wr ? sts_wdata : 4'h0)) | set_vec;
      if (fin_rx)
        rsp_q <= (rtype_q == 2'b01) ? {8'd0, rx_nxt[127:8]} : {96'd0, rx_nxt[39:8]};
    end
  end

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);
  assert_end_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> $past(cmd_out));
  assert_oe_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> present_state[0]);
  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[0]) |-> $fell(present_state[0]));
  assert_timeout_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[1]) |-> $past(st) == S_WAIT);
  assert_dat_under_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    present_state[1] |-> present_state[0]);
endmodule

// File: tb/test_sd_cmd_issuer.sv
`timescale 1ns/1ps
module test_sd_cmd_issuer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic arg_wr = 0, cmd_wr = 0, sts_wr = 0, cmd_in = 1, dat0_in = 1;
  logic [31:0] arg_wdata = 0;
  logic [15:0] cmd_wdata = 0;
  logic [3:0]  sts_wdata = 0;
  logic cmd_out, cmd_oe;
  logic [31:0] present_state;
  logic [3:0] int_status;
  logic [127:0] response;

  int tests = 0, fails = 0;
  logic [47:0] exp_q[$];
  logic [47:0] mon_sh;
  int mon_n = 0;

  always #2.5 clk = ~clk;

  sd_cmd_issuer i_sd_cmd_issuer (.*);

  function automatic logic [6:0] crc_ref(input logic [39:0] d);
    logic [46:0] m;
    m = {d, 7'd0};
    for (int i = 46; i >= 7; i--)
      if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
    return m[6:0];
  endfunction

  function automatic logic [135:0] mk48(input logic [5:0] idx, input logic [31:0] pl, input bit bad);
    logic [6:0] c;
    c = crc_ref({2'b00, idx, pl}) ^ (bad ? 7'h01 : 7'h00);
    return {88'd0, 2'b00, idx, pl, c, 1'b1};
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmd_oe) begin
      mon_sh = {mon_sh[46:0], cmd_out};
      mon_n++;
      if (mon_n == 48) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk("R3", "unexpected frame", mon_sh, 48'd0);
        else chk("R2", "frame", mon_sh, exp_q.pop_front());
      end
    end
  end

  task automatic start_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [5:0] flags);
    logic [39:0] h;
    @(negedge clk); arg_wr = 1; arg_wdata = arg;
    @(negedge clk); arg_wr = 0; cmd_wr = 1; cmd_wdata = {2'b00, idx, 2'b00, flags[5:3], 1'b0, flags[1:0]};
    h = {2'b01, idx, arg};
    exp_q.push_back({h, crc_ref(h), 1'b1});
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wait_tx();
    while (cmd_oe) @(negedge clk);
  endtask

  task automatic send_rsp(input logic [135:0] b, input int len, input int ncr, input bit clr, input logic [3:0] mask);
    repeat (ncr) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = b[i];
      if (i == 0 && clr) begin sts_wr = 1; sts_wdata = mask; end
      @(negedge clk);
    end
    cmd_in = 1; sts_wr = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); sts_wr = 1; sts_wdata = 4'hF;
    @(negedge clk); sts_wr = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (present_state[0] && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [119:0] content;
    repeat (3) @(negedge clk);
    chk("R1", "present_state", present_state, 32'h0010_0000);
    chk("R1", "int_status", int_status, 0);
    chk("R1", "response", response, 0);
    chk("R1", "oe/out", {cmd_oe, cmd_out}, 2'b01);
    rst_n = 1;

    // R4: no reply, done at end bit
    start_cmd(6'd0, 32'd0, 6'b000000);
    wait_tx();
    chk("R4", "inhibit after end bit", present_state[0], 0);
    chk("R4", "done on type 00", int_status, 4'b0001);
    clear_all();
    chk("R11", "w1c clears", int_status, 0);

    // R5 R8 R9: good 48-bit reply, checks on
    start_cmd(6'd8, 32'h0000_01AA, 6'b011010);
    wait_tx();
    chk("R3", "inhibit while waiting", present_state[0], 1);
    send_rsp(mk48(6'd8, 32'h0000_01AA, 0), 48, 2, 0, 0);
    chk("R5", "payload", response, 128'h1AA);
    chk("R5", "status good", int_status, 4'b0001);
    chk("R3", "inhibit released", present_state[0], 0);
    clear_all();

    // R8 bad CRC, enabled then disabled
    start_cmd(6'd17, 32'hDEAD_BEEF, 6'b001010);
    wait_tx(); send_rsp(mk48(6'd17, 32'h1234_5678, 1), 48, 3, 0, 0);
    chk("R8", "crc error set", int_status, 4'b0101);
    chk("R5", "payload bad crc", response, 128'h1234_5678);
    clear_all();
    start_cmd(6'd17, 32'hDEAD_BEEF, 6'b000010);
    wait_tx(); send_rsp(mk48(6'd17, 32'h1111_2222, 1), 48, 3, 0, 0);
    chk("R8", "crc ignored when off", int_status, 4'b0001);
    clear_all();

    // R9 index mismatch
    start_cmd(6'd13, 32'h0001_0000, 6'b010010);
    wait_tx(); send_rsp(mk48(6'd14, 32'h900, 0), 48, 2, 0, 0);
    chk("R9", "index error set", int_status, 4'b1001);
    clear_all();
    start_cmd(6'd13, 32'h0001_0000, 6'b000010);
    wait_tx(); send_rsp(mk48(6'd14, 32'h900, 0), 48, 2, 0, 0);
    chk("R9", "index ignored when off", int_status, 4'b0001);
    clear_all();

    // R6 136-bit reply
    content = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
    start_cmd(6'd2, 32'd0, 6'b011001);
    wait_tx(); send_rsp({2'b00, 6'b111111, content, 7'h55, 1'b1}, 136, 4, 0, 0);
    chk("R6", "long reply", response, {8'd0, content});
    chk("R6", "no checks on long reply", int_status, 4'b0001);
    clear_all();

    // R7 timeout after exactly 64 samples
    start_cmd(6'd55, 32'd0, 6'b000010);
    wait_tx(); wait_idle(n);
    chk("R7", "timeout cycles", n, 64);
    chk("R7", "timeout status", int_status, 4'b0010);
    chk("R7", "response kept", response, {8'd0, content});

    // R11 collision: done set while clear of done+timeout, set wins
    start_cmd(6'd7, 32'h0000_0042, 6'b000010);
    wait_tx(); send_rsp(mk48(6'd7, 32'hCAFE_0001, 0), 48, 2, 1, 4'b0011);
    chk("R11", "set wins over clear", int_status, 4'b0001);
    clear_all();

    // R7 start bit on the 64th sample
    start_cmd(6'd9, 32'h5, 6'b000010);
    wait_tx(); send_rsp(mk48(6'd9, 32'hABCD, 0), 48, 63, 0, 0);
    chk("R7", "late start accepted", int_status, 4'b0001);
    chk("R7", "late payload", response, 128'hABCD);
    clear_all();

    // R10 busy, data inhibit
    start_cmd(6'd6, 32'h03B7_0100, 6'b000011);
    wait_tx(); dat0_in = 0;
    send_rsp(mk48(6'd6, 32'h800, 0), 48, 2, 0, 0);
    repeat (5) @(negedge clk);
    chk("R10", "busy present_state", present_state, 32'h0000_0003);
    chk("R10", "no done while busy", int_status, 4'b0000);
    dat0_in = 1; @(negedge clk);
    chk("R10", "released", present_state, 32'h0010_0000);
    chk("R10", "done at release", int_status, 4'b0001);
    clear_all();

    // R10 busy with data-present: no data inhibit
    start_cmd(6'd12, 32'd0, 6'b100011);
    wait_tx(); dat0_in = 0;
    send_rsp(mk48(6'd12, 32'h0, 0), 48, 2, 0, 0);
    @(negedge clk);
    chk("R10", "data-present busy", present_state, 32'h0000_0001);
    dat0_in = 1; @(negedge clk);
    chk("R10", "released dp", int_status, 4'b0001);
    clear_all();

    // R3 write during frame is ignored
    start_cmd(6'd1, 32'h40FF_8000, 6'b000000);
    repeat (5) @(negedge clk);
    cmd_wr = 1; cmd_wdata = {2'b00, 6'd5, 8'h00};
    @(negedge clk); cmd_wr = 0;
    wait_tx();
    repeat (60) @(negedge clk);
    chk("R3", "no second transaction", {cmd_oe, present_state[0]}, 2'b00);
    chk("R2", "all frames seen", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule